// File: doc/BRIEF.md
# Source-Routed Virtual-Channel Packet Router

This block is a five-port packet router that moves 32-bit flits from its input ports to its output ports. It does no route computation. Each packet names its path in the head flit. The three lowest bits of the route field pick the output port at this hop. Before the head flit leaves, the router shifts the route field right by three bits, so the next router finds its own port number in the same place. Body and tail flits follow the port that their head flit opened.

Each input port has two virtual-channel FIFOs of four flits each. A packet keeps its VC number from input to output. At every output, each VC has a credit counter that mirrors the free space in the downstream buffer. A flit may leave only when its output VC holds a credit. Each output VC also has a two-state lock machine. It ties that output VC to one input VC from head to tail, so packets never interleave inside a VC. A round-robin arbiter at each output grants one eligible input VC per cycle. Each flit removed from an input FIFO produces a one-cycle credit pulse back to the upstream sender.

Lock machine per output VC. States: `VC_IDLE` (free) and `VC_BUSY` (owned by one input VC). Transitions: *claim*, from `VC_IDLE` to `VC_BUSY`, when a head flit without a tail mark is forwarded. *release*, from `VC_BUSY` to `VC_IDLE`, when the owner's tail flit is forwarded. A single-flit packet (head and tail both set) leaves the machine in `VC_IDLE`.

Top module: `vc_router`

## Requirements
- R1: While reset is held and on the first cycle after it, every `out_valid` bit and every `up_credit` bit is 0. Every output credit counter starts at the buffer depth (4).
- R2: A flit written into an empty input FIFO at one rising edge appears on its output port after the next rising edge, provided it meets no contention and holds a credit. Every flit accepted is delivered exactly once.
- R3: Flit format: bit 31 marks a head flit, bit 30 marks a tail flit, and bits 29:0 are the route field of a head flit. A head flit leaves on the output port numbered by its route bits 2:0. Later flits on the same input VC follow that port until the tail flit.
- R4: A head flit leaves with bits 31:30 kept and route bits 29:0 replaced by the old route shifted right by 3 (zeros enter at bits 29:27). Body and tail flits leave unchanged.
- R5: A flit leaves on the same VC id (0 or 1) that it arrived on. In each `in_vc` and `out_vc` field, port p uses bit p.
- R6: Once an output VC has forwarded a head flit without a tail mark, it forwards flits from no other input VC until that packet's tail flit has passed.
- R7: Each output arbitrates round robin over the ten input VCs, indexed port*2+vc. The search starts one past the last index granted. When some input VC is eligible, a grant is made in that cycle.
- R8: An output VC forwards no flit while its credit counter is zero. The counter falls by one per forwarded flit and rises by one per `dn_credit` pulse. The downstream occupancy it implies never exceeds 4.
- R9: Each flit removed from input VC k raises `up_credit[k]` for exactly one cycle, in the cycle the flit appears at the output. Here k = port*2+vc.
- R10: The two VCs of one output are independent. A VC stalled for credits does not hold back traffic on the other VC of the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit present on input port p |
| in_vc | input | 5 | VC id of the flit on input port p |
| in_flit | input | 160 | Input flits, port p at bits p*32 +: 32 |
| up_credit | output | 10 | Credit pulse to upstream for input VC port*2+vc |
| dn_credit | input | 10 | Credit pulse from downstream for output VC port*2+vc |
| out_valid | output | 5 | Flit present on output port p |
| out_vc | output | 5 | VC id of the flit on output port p |
| out_flit | output | 160 | Output flits, port p at bits p*32 +: 32 |

## Verification
The hardest state to reach from the ports is a VC whose credits have run out while the other VC of the same output keeps moving, with several heads queued behind a locked VC. The bench gets there by holding back the downstream credit returns of one output VC. It then sends a long packet on that VC and a short packet on the other VC to the same port, and releases the credits only after checking the counts. Contention is built by launching equal packet streams from two ports in the same cycle. A random phase then mixes packet lengths, destinations and credit return delays. All of this runs against a behavioural model that predicts every output on every clock.

// File: rtl/router_pkg.sv
package router_pkg;
    typedef enum logic {
        VC_IDLE = 1'b0,
        VC_BUSY = 1'b1
    } vc_state_e;
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_wr, do_rd;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) wr |-> !full);
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) rd |-> !empty);
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gidx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic          found;

    always_comb begin
        gnt   = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(ptr) + i) % N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                gidx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (found)
            ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
    end

    // R7
    work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|(gnt & req)));
endmodule

// File: rtl/rp_out_port.sv
module rp_out_port
    import router_pkg::*;
#(
    parameter int NREQ  = 10,
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int HOP_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREQ-1:0]              req,
    input  logic [NREQ*W-1:0]            req_flit,
    input  logic [NVC-1:0]               cred_ret,
    output logic [NREQ-1:0]              gnt,
    output logic                         out_valid,
    output logic [$clog2(NVC)-1:0]       out_vc,
    output logic [W-1:0]                 out_flit
);
    localparam int VC_W = $clog2(NVC);
    localparam int IW   = $clog2(NREQ);
    localparam int CW   = $clog2(DEPTH + 1);

    logic [NREQ-1:0]   elig;
    logic [IW-1:0]     gidx;
    logic              take, ghead, gtail;
    logic [W-1:0]      gflit, fwd_flit;
    logic [VC_W-1:0]   gvc;
    logic [NVC-1:0]    busy_v;
    logic [NVC*CW-1:0] cred_flat;
    logic [NVC*IW-1:0] own_flat;

    for (genvar r = 0; r < NREQ; r++) begin : g_elig
        localparam int RV = r % NVC;
        assign elig[r] = req[r] && (cred_flat[RV*CW +: CW] != '0) &&
                         (busy_v[RV] ? (own_flat[RV*IW +: IW] == IW'(r))
                                     : req_flit[r*W + W - 1]);
    end

    rr_arbiter #(.N(NREQ)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (elig),
        .gnt  (gnt),
        .gidx (gidx)
    );

    assign take  = |gnt;
    assign gflit = req_flit[gidx*W +: W];
    assign gvc   = VC_W'(32'(gidx) % NVC);
    assign ghead = gflit[W-1];
    assign gtail = gflit[W-2];
    assign fwd_flit = ghead ? {gflit[W-1:W-2], {HOP_W{1'b0}}, gflit[W-3:HOP_W]} : gflit;

    for (genvar v = 0; v < NVC; v++) begin : g_vc
        vc_state_e     st_q, st_d;
        logic [IW-1:0] own_q;
        logic [CW-1:0] cr_q;
        logic          fwd_here;

        assign fwd_here = take && (gvc == VC_W'(v));

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                VC_IDLE: if (fwd_here && ghead && !gtail) st_d = VC_BUSY;
                VC_BUSY: if (fwd_here && gtail)           st_d = VC_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= VC_IDLE;
            else        st_q <= st_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                  own_q <= '0;
            else if (fwd_here && ghead)  own_q <= gidx;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cr_q <= CW'(DEPTH);
            else        cr_q <= cr_q - CW'(fwd_here) + CW'(cred_ret[v]);
        end

        assign busy_v[v]             = (st_q == VC_BUSY);
        assign cred_flat[v*CW +: CW] = cr_q;
        assign own_flat[v*IW +: IW]  = own_q;

        // R8
        credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cr_q <= CW'(DEPTH));
        // R8
        zero_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cr_q == '0 && !cred_ret[v]) |=> !(out_valid && out_vc == VC_W'(v)));
        // R6
        lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == VC_BUSY && fwd_here) |-> (gidx == own_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vc    <= '0;
            out_flit  <= '0;
        end else begin
            out_valid <= take;
            out_vc    <= gvc;
            out_flit  <= fwd_flit;
        end
    end
endmodule

// File: rtl/vc_router.sv
module vc_router #(
    parameter int NPORT = 5,
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int HOP_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORT-1:0]               in_valid,
    input  logic [NPORT*$clog2(NVC)-1:0]   in_vc,
    input  logic [NPORT*W-1:0]             in_flit,
    output logic [NPORT*NVC-1:0]           up_credit,
    input  logic [NPORT*NVC-1:0]           dn_credit,
    output logic [NPORT-1:0]               out_valid,
    output logic [NPORT*$clog2(NVC)-1:0]   out_vc,
    output logic [NPORT*W-1:0]             out_flit
);
    localparam int VC_W = $clog2(NVC);
    localparam int NREQ = NPORT * NVC;

    logic [NREQ*W-1:0]  q_flit;
    logic [NREQ-1:0]    q_empty, pop;
    logic [HOP_W-1:0]   tgt [NREQ];
    logic [NREQ-1:0]    gnt_m [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        for (genvar v = 0; v < NVC; v++) begin : g_vc
            localparam int R = p * NVC + v;
            logic [W-1:0]     head_flit;
            logic [HOP_W-1:0] cur_q;

            vc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
                .clk  (clk),
                .rst_n(rst_n),
                .wr   (in_valid[p] && in_vc[p*VC_W +: VC_W] == VC_W'(v)),
                .din  (in_flit[p*W +: W]),
                .rd   (pop[R]),
                .dout (head_flit),
                .empty(q_empty[R])
            );

            always_ff @(posedge clk) begin
                if (!rst_n)                         cur_q <= '0;
                else if (pop[R] && head_flit[W-1])  cur_q <= head_flit[HOP_W-1:0];
            end

            assign q_flit[R*W +: W] = head_flit;
            assign tgt[R] = head_flit[W-1] ? head_flit[HOP_W-1:0] : cur_q;
        end
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++) pop = pop | gnt_m[o];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) up_credit <= '0;
        else        up_credit <= pop;
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [NREQ-1:0] req_o;
        for (genvar r = 0; r < NREQ; r++) begin : g_req
            assign req_o[r] = !q_empty[r] && (tgt[r] == HOP_W'(o));
        end

        rp_out_port #(
            .NREQ(NREQ), .NVC(NVC), .DEPTH(DEPTH), .W(W), .HOP_W(HOP_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_o),
            .req_flit (q_flit),
            .cred_ret (dn_credit[o*NVC +: NVC]),
            .gnt      (gnt_m[o]),
            .out_valid(out_valid[o]),
            .out_vc   (out_vc[o*VC_W +: VC_W]),
            .out_flit (out_flit[o*W +: W])
        );

        // R3
        route_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|gnt_m[o]) |-> (|(gnt_m[o] & ~q_empty)));
    end

    // R9
    credit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(up_credit) == $countones(out_valid));
endmodule

// File: tb/sim_vc_router.sv
module sim_vc_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   in_valid = '0;
    logic [4:0]   in_vc = '0;
    logic [159:0] in_flit = '0;
    logic [9:0]   up_credit;
    logic [9:0]   dn_credit = '0;
    logic [4:0]   out_valid;
    logic [4:0]   out_vc;
    logic [159:0] out_flit;

    always #4 clk = ~clk;

    vc_router u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
        .up_credit(up_credit), .dn_credit(dn_credit), .out_valid(out_valid),
        .out_vc(out_vc), .out_flit(out_flit)
    );

    int nchk = 0, nfail = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq [10][$];
    int          mcur [10];
    int          mcred [10];
    int          mlock [10];
    int          mptr [5];
    int          g [5];
    bit   [4:0]  exp_valid;
    int          exp_vc [5];
    logic [31:0] exp_flit [5];
    bit   [9:0]  exp_cr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 10; k++) begin
                mq[k].delete(); mcur[k] = 0; mcred[k] = 4; mlock[k] = -1;
            end
            for (int o = 0; o < 5; o++) mptr[o] = 0;
            exp_valid = '0; exp_cr = '0;
        end else begin
            for (int o = 0; o < 5; o++) begin
                g[o] = -1;
                for (int i = 0; i < 10; i++) begin
                    int r, v, t, ov;
                    logic [31:0] f;
                    r = (mptr[o] + i) % 10;
                    v = r % 2;
                    ov = o * 2 + v;
                    if (g[o] < 0 && mq[r].size() > 0) begin
                        f = mq[r][0];
                        t = f[31] ? int'(f[2:0]) : mcur[r];
                        if (t == o && mcred[ov] > 0 &&
                            ((mlock[ov] < 0) ? f[31] : (mlock[ov] == r)))
                            g[o] = r;
                    end
                end
            end
            exp_cr = '0;
            for (int o = 0; o < 5; o++) begin
                exp_valid[o] = 1'b0;
                if (g[o] >= 0) begin
                    int r, v, ov;
                    logic [31:0] f;
                    r = g[o]; v = r % 2; ov = o * 2 + v;
                    f = mq[r].pop_front();
                    if (f[31]) mcur[r] = int'(f[2:0]);
                    if (f[31] && !f[30]) mlock[ov] = r;
                    if (f[30]) mlock[ov] = -1;
                    mcred[ov]--;
                    mptr[o] = (r + 1) % 10;
                    exp_valid[o] = 1'b1;
                    exp_vc[o] = v;
                    exp_flit[o] = f[31] ? {f[31:30], 3'b000, f[29:3]} : f;
                    exp_cr[r] = 1'b1;
                end
            end
            for (int k = 0; k < 10; k++) if (dn_credit[k]) mcred[k]++;
            for (int p = 0; p < 5; p++)
                if (in_valid[p]) mq[p * 2 + int'(in_vc[p])].push_back(in_flit[p*32 +: 32]);
        end
    end

    // ---------------- stimulus / monitor state ----------------
    logic [31:0] sq [10][$];
    int  ucred [10], dpend [10], occ [10], rxc [10], own_src [10];
    bit  hold [10];
    bit  fast = 1'b1;
    int  seq = 0, tx_total = 0, rx_total = 0;
    bit  r2_watch = 1'b0;
    int  r2_tx = -1, r2_rx = -1;
    bit  fair_on = 1'b0;
    int  fsrc [$];

    task automatic make_pkt(input int p, input int v, input int dest, input int len);
        for (int i = 0; i < len; i++) begin
            logic [31:0] f;
            bit hd, tl;
            hd = (i == 0); tl = (i == len - 1);
            if (hd) f = {1'b1, tl, 4'(p * 2 + v), 20'(seq), 3'(dest), 3'(dest)};
            else    f = {1'b0, tl, 4'(p * 2 + v), 20'(seq), 3'b000, 3'(dest)};
            seq++;
            sq[p * 2 + v].push_back(f);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            // R1
            chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
            chk(up_credit == '0, "R1", "up_credit in reset", up_credit, 0);
        end else begin
            for (int o = 0; o < 5; o++) begin
                chk(out_valid[o] == exp_valid[o], "R2", $sformatf("out_valid[%0d]", o),
                    out_valid[o], exp_valid[o]);
                if (exp_valid[o] && out_valid[o]) begin
                    chk(int'(out_vc[o]) == exp_vc[o], "R5", $sformatf("out_vc[%0d]", o),
                        out_vc[o], exp_vc[o]);
                    chk(out_flit[o*32 +: 32] == exp_flit[o], "R4", $sformatf("out_flit[%0d]", o),
                        out_flit[o*32 +: 32], exp_flit[o]);
                end
            end
            chk(up_credit == exp_cr, "R9", "up_credit", up_credit, exp_cr);
            for (int o = 0; o < 5; o++) begin
                if (out_valid[o]) begin
                    logic [31:0] f;
                    int k, src;
                    f = out_flit[o*32 +: 32];
                    k = o * 2 + int'(out_vc[o]);
                    rxc[k]++; rx_total++; dpend[k]++; occ[k]++;
                    // R3: dest copy in bits 2:0 must name this port
                    chk(int'(f[2:0]) == o, "R3", "port of flit", o, f[2:0]);
                    // R8: downstream buffer never overrun
                    chk(occ[k] <= 4, "R8", "downstream occupancy", occ[k], 4);
                    src = f[31] ? int'(f[26:23]) : int'(f[29:26]);
                    if (f[31]) own_src[k] = src;
                    else chk(src == own_src[k], "R6", "packet source in locked VC", src, own_src[k]);
                    if (r2_watch && o == 2) r2_rx = cyc;
                    if (fair_on && o == 3) fsrc.push_back(src);
                end
            end
        end
        for (int k = 0; k < 10; k++) if (up_credit[k]) ucred[k]++;
        for (int k = 0; k < 10; k++) begin
            dn_credit[k] = 1'b0;
            if (!hold[k] && dpend[k] > 0 && (fast || ($urandom % 2 == 0))) begin
                dn_credit[k] = 1'b1; dpend[k]--; occ[k]--;
            end
        end
        for (int p = 0; p < 5; p++) begin
            bit sent;
            sent = 1'b0;
            in_valid[p] = 1'b0;
            for (int j = 0; j < 2; j++) begin
                int v, r;
                v = (j + cyc) % 2; r = p * 2 + v;
                if (rst_n && !sent && sq[r].size() > 0 && ucred[r] > 0) begin
                    in_flit[p*32 +: 32] = sq[r].pop_front();
                    in_vc[p] = v[0];
                    in_valid[p] = 1'b1;
                    ucred[r]--; tx_total++; sent = 1'b1;
                    if (r2_watch && r == 0) r2_tx = cyc;
                end
            end
        end
    end

    task automatic drain();
        bit busy;
        for (int n = 0; n < 2000; n++) begin
            busy = 1'b0;
            for (int k = 0; k < 10; k++) if (sq[k].size() > 0 || mq[k].size() > 0) busy = 1'b1;
            if (!busy) break;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 10; k++) begin
            ucred[k] = 4; dpend[k] = 0; occ[k] = 0; rxc[k] = 0; own_src[k] = 0; hold[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after reset is quiet
        chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);

        // R2: lone single-flit packet, input 0 VC0 to output 2
        r2_watch = 1'b1;
        make_pkt(0, 0, 2, 1);
        repeat (8) @(negedge clk);
        r2_watch = 1'b0;
        chk(r2_rx - r2_tx == 2, "R2", "latency in cycles", r2_rx - r2_tx, 2);

        // R3/R4: one packet from each port to differing outputs
        for (int p = 0; p < 5; p++) make_pkt(p, p % 2, (p + 3) % 5, 3);
        drain();

        // R6: two long packets contend for output 4 VC0
        make_pkt(1, 0, 4, 5);
        make_pkt(3, 0, 4, 5);
        drain();
        chk(rxc[8] == 10, "R6", "flits on out4 vc0", rxc[8], 10);

        // R8/R10: starve output 1 VC0 of credits, VC1 keeps moving
        for (int k = 0; k < 10; k++) rxc[k] = 0;
        hold[2] = 1'b1;
        make_pkt(0, 0, 1, 8);
        make_pkt(2, 1, 1, 3);
        repeat (40) @(negedge clk);
        chk(rxc[2] == 4, "R8", "flits sent with no credit return", rxc[2], 4);
        chk(rxc[3] == 3, "R10", "other VC not blocked", rxc[3], 3);
        hold[2] = 1'b0;
        drain();
        chk(rxc[2] == 8, "R8", "flits after credit release", rxc[2], 8);

        // R7: two equal streams into output 3 VC1 alternate
        fair_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
            make_pkt(0, 1, 3, 1);
            make_pkt(4, 1, 3, 1);
        end
        drain();
        fair_on = 1'b0;
        chk(fsrc.size() == 12, "R7", "fair stream length", fsrc.size(), 12);
        for (int i = 0; i + 1 < 10 && i + 1 < fsrc.size(); i++)
            chk(fsrc[i] != fsrc[i + 1], "R7", "alternation", fsrc[i + 1], fsrc[i] == 1 ? 9 : 1);

        // mixed random traffic with slow credit return
        fast = 1'b0;
        for (int n = 0; n < 300; n++) begin
            make_pkt($urandom % 5, $urandom % 2, $urandom % 5, 1 + $urandom % 5);
            if (n % 5 == 0) repeat (6) @(negedge clk);
        end
        drain();
        chk(rx_total == tx_total, "R2", "all flits delivered", rx_total, tx_total);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule